// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds a joint translation lookaside buffer organised as a number of sets, each with a small number of ways. Software does not reach the entries directly. Instead it loads three staging registers and then writes a command code. The staging registers are a page descriptor word (virtual page, address-space identifier, valid flag), a frame descriptor word (physical frame and permission bits, stored opaquely) and an entry index. The engine runs each command in a fixed two cycles and reports the result in the staging registers.

The commands are as follows. A lookup finds the entry that matches a descriptor, or reports a miss or a duplicate. A slot allocation returns a free way in the descriptor's set, or a round-robin victim when the set is full. A store places the staged words at the indexed entry, with or without a pulse that tells the small per-pipeline translation caches to drop their contents. A fetch copies an entry back into the staging registers, so any slot can be inspected. A standalone command raises only the invalidate pulse. A refill path typically runs a lookup first, allocates a slot on a miss, stores the frame word, and then commits.

Top module: `tlbx_engine`

## Requirements
- R1: After synchronous reset the page word, frame word and index outputs are zero, busy and the invalidate pulse are low, and every entry is invalid, so any lookup misses.
- R2: Register select 0 loads the page word, 1 the frame word, 2 the index and 3 the command code (bits 2:0). The set of a page word is its bits [PAGE_BITS+SET_W-1:PAGE_BITS]. Entry index = set*WAYS + way, so an index's low WAY_W bits are the way and the bits above are the set.
- R3: A lookup (code 1) compares the virtual page bits [DW-1:PAGE_BITS] and the identifier bits [ASID_W-1:0] of the page word against the valid ways of its set. On exactly one match, the index becomes that entry's linear index.
- R4: A lookup with no match sets the index to 0x8000_0000 (the error flag is bit 31). A match in two or more ways sets it to 0xC000_0000.
- R5: Slot allocation (code 2) sets the index to the lowest-numbered invalid way of the page word's set.
- R6: When every way of the set is valid, allocation returns the way held in a single victim pointer. The pointer starts at 0 after reset and advances by one modulo WAYS on each such use.
- R7: Store (code 3) writes both staged words at the indexed entry, with validity taken from page word bit VALID_POS. The invalidate output pulses high for exactly one cycle, in the cycle busy falls.
- R8: Store without invalidate (code 4) writes the entry in the same way and leaves the invalidate output low.
- R9: The invalidate command (code 6) pulses the invalidate output for one cycle and leaves every entry unchanged.
- R10: Fetch (code 5) loads the page and frame words from the indexed entry. The page word's bit VALID_POS shows that entry's validity.
- R11: Storing an all-zero page word and frame word erases the entry: later lookups of its old descriptor miss, and a fetch returns zeros.
- R12: After the cycle in which a command code is written, busy is high for exactly two cycles. Register writes presented while busy is high are ignored. Results appear in the cycle busy falls.
- R13: Codes 0 and 7 run for the same two cycles but change no register and no entry, and raise no invalidate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 page, 1 frame, 2 index, 3 command) |
| reg_wdata | input | DW | Register write data |
| pd0_q | output | DW | Staged page descriptor word |
| pd1_q | output | DW | Staged frame descriptor word |
| index_q | output | DW | Entry index or lookup error code |
| busy | output | 1 | Command in progress |
| utlb_inval | output | 1 | One-cycle invalidate pulse for the small translation caches |

## Verification
The bound checker watches the command timing on every cycle. It checks that busy lasts exactly two cycles, that the staged outputs hold still during the first busy cycle, and that the invalidate pulse is a single cycle aligned with busy falling. Behaviours that depend on stored contents can only be shown by the bench's scenarios on a small 8-set, 4-way build: hit indices, miss and duplicate codes, lowest-free and round-robin allocation, erase and fetch. The bench fills, fetches and looks up every entry of that build, and models the victim pointer arithmetically.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    SEL_PAGE  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_INDEX = 2'd2,
    SEL_CMD   = 2'd3
  } tlbx_sel_e;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LOOKUP   = 3'd1,
    OP_ALLOC    = 3'd2,
    OP_STORE    = 3'd3,
    OP_STORE_NI = 3'd4,
    OP_FETCH    = 3'd5,
    OP_UINV     = 3'd6,
    OP_RSVD     = 3'd7
  } tlbx_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } tlbx_state_e;
endpackage

// File: rtl/tlbx_way_ram.sv
// One way of the buffer: descriptor words in inferable RAM, validity in
// resettable flops so reset empties the whole buffer in one cycle.
module tlbx_way_ram #(
  parameter int SETS = 128,
  parameter int DW   = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SET_W-1:0] waddr,
  input  logic [DW-1:0]    wpage,
  input  logic [DW-1:0]    wframe,
  input  logic             wvalid,
  input  logic [SET_W-1:0] raddr,
  output logic [DW-1:0]    rpage,
  output logic [DW-1:0]    rframe,
  output logic             rvalid
);
  logic [DW-1:0]   page_mem  [SETS];
  logic [DW-1:0]   frame_mem [SETS];
  logic [SETS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (we) begin
      page_mem[waddr]  <= wpage;
      frame_mem[waddr] <= wframe;
    end
    rpage  <= page_mem[raddr];
    rframe <= frame_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) vld_q[waddr] <= wvalid;
      rvalid <= vld_q[raddr];
    end
  end
endmodule

// File: rtl/tlbx_way_select.sv
// Compares a key against all ways of a set; encodes hit and free ways.
module tlbx_way_select #(
  parameter int WAYS      = 4,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 13,
  parameter int ASID_W    = 8,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic [DW-1:0]            key,
  input  logic [WAYS-1:0][DW-1:0]  ent_page,
  input  logic [WAYS-1:0]          ent_vld,
  output logic                     hit_any,
  output logic                     hit_multi,
  output logic [WAY_W-1:0]         hit_way,
  output logic                     free_any,
  output logic [WAY_W-1:0]         free_way
);
  localparam logic [DW-1:0] CMP_MASK =
    ({DW{1'b1}} << PAGE_BITS) | DW'((64'd1 << ASID_W) - 64'd1);

  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (((ent_page[g] ^ key) & CMP_MASK) == '0);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])    hit_way  = WAY_W'(w);
      if (!ent_vld[w]) free_way = WAY_W'(w);
    end
    hit_any   = |match;
    hit_multi = ($countones(match) > 1);
    free_any  = ~&ent_vld;
  end
endmodule

// File: rtl/tlbx_engine.sv
module tlbx_engine #(
  parameter int SETS      = 128,
  parameter int WAYS      = 4,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 13,
  parameter int ASID_W    = 8,
  parameter int VALID_POS = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] pd0_q,
  output logic [DW-1:0] pd1_q,
  output logic [DW-1:0] index_q,
  output logic          busy,
  output logic          utlb_inval
);
  import tlbx_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam logic [DW-1:0] MISS_CODE = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] DUP_CODE  = MISS_CODE | (DW'(1) << (DW - 2));

  tlbx_state_e state_q;
  tlbx_op_e    op_q;
  logic [WAY_W-1:0] victim_q;

  logic [SET_W-1:0] key_set, idx_set, rd_set;
  logic [WAY_W-1:0] idx_way;
  logic             accept, is_store, in_exec;

  logic [WAYS-1:0][DW-1:0] ent_page, ent_frame;
  logic [WAYS-1:0]         ent_vld;
  logic                    hit_any, hit_multi, free_any;
  logic [WAY_W-1:0]        hit_way, free_way;
  logic [DW-1:0]           sel_page;

  assign busy     = (state_q != ST_IDLE);
  assign accept   = reg_we && !busy;
  assign in_exec  = (state_q == ST_EXEC);
  assign key_set  = pd0_q[PAGE_BITS +: SET_W];
  assign idx_set  = index_q[WAY_W +: SET_W];
  assign idx_way  = index_q[WAY_W-1:0];
  assign is_store = (op_q == OP_STORE) || (op_q == OP_STORE_NI);
  assign rd_set   = ((op_q == OP_LOOKUP) || (op_q == OP_ALLOC)) ? key_set : idx_set;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlbx_way_ram #(.SETS(SETS), .DW(DW)) u_ram (
      .clk    (clk),
      .rst    (rst),
      .we     (in_exec && is_store && (idx_way == WAY_W'(g))),
      .waddr  (idx_set),
      .wpage  (pd0_q),
      .wframe (pd1_q),
      .wvalid (pd0_q[VALID_POS]),
      .raddr  (rd_set),
      .rpage  (ent_page[g]),
      .rframe (ent_frame[g]),
      .rvalid (ent_vld[g])
    );
  end

  tlbx_way_select #(
    .WAYS(WAYS), .DW(DW), .PAGE_BITS(PAGE_BITS), .ASID_W(ASID_W)
  ) u_sel (
    .key       (pd0_q),
    .ent_page  (ent_page),
    .ent_vld   (ent_vld),
    .hit_any   (hit_any),
    .hit_multi (hit_multi),
    .hit_way   (hit_way),
    .free_any  (free_any),
    .free_way  (free_way)
  );

  always_comb begin
    sel_page            = ent_page[idx_way];
    sel_page[VALID_POS] = ent_vld[idx_way];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_NOP;
      victim_q   <= '0;
      pd0_q      <= '0;
      pd1_q      <= '0;
      index_q    <= '0;
      utlb_inval <= 1'b0;
    end else begin
      utlb_inval <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            case (tlbx_sel_e'(reg_sel))
              SEL_PAGE:  pd0_q   <= reg_wdata;
              SEL_FRAME: pd1_q   <= reg_wdata;
              SEL_INDEX: index_q <= reg_wdata;
              default: begin
                op_q    <= tlbx_op_e'(reg_wdata[2:0]);
                state_q <= ST_FETCH;
              end
            endcase
          end
        end
        ST_FETCH: state_q <= ST_EXEC;
        default: begin
          state_q <= ST_IDLE;
          case (op_q)
            OP_LOOKUP: begin
              if (hit_multi)    index_q <= DUP_CODE;
              else if (hit_any) index_q <= {{(DW-IDX_W){1'b0}}, key_set, hit_way};
              else              index_q <= MISS_CODE;
            end
            OP_ALLOC: begin
              if (free_any) begin
                index_q <= {{(DW-IDX_W){1'b0}}, key_set, free_way};
              end else begin
                index_q  <= {{(DW-IDX_W){1'b0}}, key_set, victim_q};
                victim_q <= victim_q + 1'b1;
              end
            end
            OP_FETCH: begin
              pd0_q <= sel_page;
              pd1_q <= ent_frame[idx_way];
            end
            OP_STORE, OP_UINV: utlb_inval <= 1'b1;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/tlbx_engine_chk.sv
module tlbx_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          utlb_inval,
  input logic [DW-1:0] pd0_q,
  input logic [DW-1:0] pd1_q,
  input logic [DW-1:0] index_q
);
  p_busy_second_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  p_busy_ends_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  p_regs_hold_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> ($stable(pd0_q) && $stable(pd1_q) && $stable(index_q)));

  p_inval_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    utlb_inval |-> (!busy && $past(busy)));

  p_inval_single_r9: assert property (@(posedge clk) disable iff (rst)
    utlb_inval |=> !utlb_inval);
endmodule

bind tlbx_engine tlbx_engine_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .utlb_inval (utlb_inval),
  .pd0_q      (pd0_q),
  .pd1_q      (pd1_q),
  .index_q    (index_q)
);

// File: tb/tlbx_engine_test.sv
module tlbx_engine_test;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int NENT = SETS * WAYS;
  localparam int DW   = 32;
  localparam logic [31:0] MISS = 32'h8000_0000;
  localparam logic [31:0] DUP  = 32'hC000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] pd0_q, pd1_q, index_q;
  logic busy, utlb_inval;

  int checks = 0;
  int errs   = 0;

  always #4 clk = ~clk;

  tlbx_engine #(.SETS(SETS), .WAYS(WAYS), .DW(DW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pd0_q(pd0_q), .pd1_q(pd1_q),
    .index_q(index_q), .busy(busy), .utlb_inval(utlb_inval)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int set, input int uniq, input int asid, input bit v);
    return (32'((uniq << 3) | set) << 13) | (32'(v) << 10) | 32'(asid & 8'hff);
  endfunction

  function automatic logic [31:0] page_of(input int i);
    return mk(i / WAYS, i + 1, i * 7 + 3, 1'b1);
  endfunction

  function automatic logic [31:0] frame_of(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0101_0107);
  endfunction

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic run(input logic [2:0] op, output logic pulsed,
                     output logic b1, output logic b2, output logic b3);
    @(negedge clk); reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'(op);
    @(negedge clk); reg_we = 1'b0; b1 = busy;
    @(negedge clk); b2 = busy;
    @(negedge clk); b3 = busy; pulsed = utlb_inval;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R12 watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic p, b1, b2, b3;
    int vict;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 page", pd0_q, 0); chk("R1 frame", pd1_q, 0);
    chk("R1 index", index_q, 0);
    chk("R1 busy/inval", {30'd0, busy, utlb_inval}, 0);
    wreg(2'd0, page_of(0)); run(3'd1, p, b1, b2, b3);
    chk("R1 empty lookup", index_q, MISS);

    // fill every entry without invalidate
    for (int i = 0; i < NENT; i++) begin
      wreg(2'd2, 32'(i)); wreg(2'd0, page_of(i)); wreg(2'd1, frame_of(i));
      run(3'd4, p, b1, b2, b3);
      chk("R8 no pulse", {31'd0, p}, 0);
      if (i == 0) chk("R12 busy 1,1,0", {29'd0, b1, b2, b3}, 32'b110);
    end
    // fetch every entry
    for (int i = 0; i < NENT; i++) begin
      wreg(2'd0, 0); wreg(2'd1, 0); wreg(2'd2, 32'(i));
      run(3'd5, p, b1, b2, b3);
      chk("R10 R2 fetch page", pd0_q, page_of(i));
      chk("R10 fetch frame", pd1_q, frame_of(i));
    end
    // look up every entry
    for (int i = 0; i < NENT; i++) begin
      wreg(2'd0, page_of(i)); run(3'd1, p, b1, b2, b3);
      chk("R3 R2 lookup hit", index_q, 32'(i));
    end
    wreg(2'd0, page_of(5) ^ 32'h1); run(3'd1, p, b1, b2, b3);
    chk("R4 miss other asid", index_q, MISS);

    // busy blocks writes; invalidate-only command
    wreg(2'd0, 32'h1111_2222);
    @(negedge clk); reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd6;
    @(negedge clk); reg_sel = 2'd0; reg_wdata = 32'h3333_4444;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk); p = utlb_inval;
    chk("R12 write ignored", pd0_q, 32'h1111_2222);
    chk("R9 pulse", {31'd0, p}, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, utlb_inval}, 0);
    wreg(2'd2, 9); run(3'd5, p, b1, b2, b3);
    chk("R9 entry kept", pd0_q, page_of(9));

    // normal store
    wreg(2'd2, 6); wreg(2'd0, mk(1, 100, 8'h55, 1)); wreg(2'd1, 32'hDEAD_0001);
    run(3'd3, p, b1, b2, b3);
    chk("R7 pulse", {31'd0, p}, 1);
    wreg(2'd0, 0); run(3'd5, p, b1, b2, b3);
    chk("R7 stored page", pd0_q, mk(1, 100, 8'h55, 1));
    chk("R7 stored frame", pd1_q, 32'hDEAD_0001);

    // erase entries 13 and 15 (set 3 ways 1 and 3)
    wreg(2'd0, 0); wreg(2'd1, 0);
    wreg(2'd2, 13); run(3'd3, p, b1, b2, b3);
    wreg(2'd2, 15); run(3'd3, p, b1, b2, b3);
    wreg(2'd0, page_of(13)); run(3'd1, p, b1, b2, b3);
    chk("R11 erased miss", index_q, MISS);
    wreg(2'd2, 13); run(3'd5, p, b1, b2, b3);
    chk("R11 erased fetch", pd0_q | pd1_q, 0);

    // allocation: lowest free way
    wreg(2'd0, mk(3, 77, 1, 1)); run(3'd2, p, b1, b2, b3);
    chk("R5 lowest free", index_q, 13);
    run(3'd4, p, b1, b2, b3);
    run(3'd2, p, b1, b2, b3);
    chk("R5 next free", index_q, 15);

    // allocation on a full set: round robin from 0
    vict = 0;
    wreg(2'd0, mk(0, 500, 2, 1));
    for (int k = 0; k < WAYS + 2; k++) begin
      run(3'd2, p, b1, b2, b3);
      chk("R6 victim", index_q, 32'(vict));
      vict = (vict + 1) % WAYS;
    end

    // duplicate in set 2
    wreg(2'd0, mk(2, 200, 9, 1)); wreg(2'd1, 32'h55);
    wreg(2'd2, 8); run(3'd4, p, b1, b2, b3);
    wreg(2'd2, 9); run(3'd4, p, b1, b2, b3);
    run(3'd1, p, b1, b2, b3);
    chk("R4 duplicate", index_q, DUP);

    // no-op codes
    wreg(2'd2, 20); wreg(2'd0, 32'h0BAD_F00D);
    run(3'd0, p, b1, b2, b3);
    chk("R13 code0 no pulse", {29'd0, p, b1, b2}, 32'b011);
    run(3'd7, p, b1, b2, b3);
    chk("R13 code7 no pulse", {31'd0, p}, 0);
    chk("R13 page kept", pd0_q, 32'h0BAD_F00D);
    chk("R13 index kept", index_q, 20);
    run(3'd5, p, b1, b2, b3);
    chk("R13 entry kept", pd0_q, page_of(20));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule